// File: doc/BRIEF.md
# Little-Endian Byte/Word Load-Store Adapter

This block sits between a register (an accumulator or one entry of a register file) and a memory array whose words are 16 bits wide. Software-visible addresses count bytes. The adapter accepts one load or store request at a time and turns it into a word-indexed memory command with per-byte write strobes. Each word holds two bytes, and the byte at the lower address is the least significant one. When the memory's read data comes back one cycle later, the adapter shapes it into a register-width result.

A byte load puts the selected byte into the low eight bits of the result and fills the upper eight bits with zero. A byte store writes only the low eight bits of the register into the selected byte, and the other byte of that word keeps its value. A word access at an odd address is refused. The refused access causes no memory activity, and its response carries a misaligned flag.

Requests arrive on a valid/ready port. A request must stay stable until it is accepted, and a request is accepted on a clock edge where both `req_valid` and `req_ready` are high. Every request, loads and stores alike, produces exactly one response, and responses leave in request order on a second valid/ready port. A response stays stable until `rsp_ready` takes it. At most one request is in flight at any time. While the response register is full and `rsp_ready` is low, `req_ready` stays low, so back-pressure from the consumer stalls the producer. The memory command pins are plain strobes. The memory samples them on the acceptance edge and presents its read data after that edge.

Top module: `lsu_byte_word_adapter`

## Requirements
- R1: On an accepted access that is not refused, `mem_en` is high and `mem_addr` equals the byte address shifted right by one. `mem_en` is never high without an accepted request.
- R2: An accepted word store (`req_word`=1) at an even address sets both strobes (`mem_be`=2'b11), drives `mem_we`, and passes all 16 register bits to `mem_wdata` unchanged.
- R3: An accepted byte store (`req_word`=0) sets exactly one strobe. Address bit 0 selects the lane: 1 selects the high lane (`mem_be`=2'b10), 0 selects the low lane (`mem_be`=2'b01). Register bits 7:0 are copied onto both lanes of `mem_wdata`. Register bits 15:8 have no effect, and the other byte of the word keeps its value.
- R4: A word load at an even address returns the whole 16-bit memory word in `rsp_data` with `rsp_misaligned`=0.
- R5: A byte load returns the byte at address bit 0 in `rsp_data[7:0]`: the high lane when the bit is 1, the low lane when it is 0. `rsp_data[15:8]` is zero.
- R6: A word access at an odd address drives `mem_en`=0 and `mem_we`=0. Its response has `rsp_misaligned`=1 and `rsp_data`=0, and the addressed memory is left unchanged.
- R7: The response for a request accepted on edge k becomes valid on edge k+2, and `rsp_valid` is low in between. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_misaligned` hold their values. A store's response has `rsp_data`=0 and `rsp_misaligned`=0.
- R8: `req_ready` is low while a request is in flight, and it is low while a response is held with `rsp_ready` low.
- R9: During reset, `rsp_valid`=0 and `req_ready`=1. `mem_en`=0 as long as no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Adapter can accept a request |
| req_addr | input | 12 | Byte address |
| req_word | input | 1 | Access size: 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 16 | Register value for stores |
| mem_en | output | 1 | Memory command valid this cycle |
| mem_we | output | 1 | Memory command is a write |
| mem_addr | output | 11 | Word index |
| mem_be | output | 2 | Byte write strobes, bit 0 = low lane |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | Word read from memory, valid the cycle after a read command |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 16 | Load result, zero for stores and refused accesses |
| rsp_misaligned | output | 1 | The access was a word access at an odd address |

## Verification
The bench first runs directed pairs. A word written at an even address is read back as two byte loads, and this shows whether the lane order is little-endian and whether the upper bits are zero-extended. A byte store whose register value has nonzero upper bits is followed by a word load, which exposes any write that reaches the neighbouring byte or leaks the upper bits. Word accesses at odd addresses are followed by an aligned reload of the same word, which separates a correctly suppressed write from a merely flagged one. A long mixed sequence of loads and stores over a small address window then runs while the response consumer toggles its ready at random, and a held-response stall checks latency, stability and blocking.

// File: rtl/lsu_adapt_pkg.sv
`timescale 1ns/1ps
package lsu_adapt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/lsu_lane_steer.sv
`timescale 1ns/1ps
// Turns a byte-addressed request into a word-indexed memory command.
module lsu_lane_steer
  import lsu_adapt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DATA_W  = LANES * BYTE_W,
  localparam int unsigned LSB_W   = $clog2(LANES),
  localparam int unsigned MADDR_W = ADDR_W - LSB_W
) (
  input  logic               fire,
  input  logic [ADDR_W-1:0]  addr,
  input  acc_size_e          size,
  input  logic               is_write,
  input  logic [DATA_W-1:0]  wdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]   mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [LSB_W-1:0]   lane,
  output logic               misaligned
);
  logic is_word;

  assign is_word    = (size == ACC_WORD);
  assign lane       = addr[LSB_W-1:0];
  assign misaligned = is_word && (lane != '0);
  assign mem_addr   = addr[ADDR_W-1:LSB_W];
  assign mem_en     = fire && !misaligned;
  assign mem_we     = mem_en && is_write;

  // One strobe and one data byte per lane; byte stores copy the low register byte everywhere.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_hit;
    assign lane_hit = (lane == LSB_W'(g));
    assign mem_be[g] = mem_we && (is_word || lane_hit);
    assign mem_wdata[g*BYTE_W +: BYTE_W] =
      is_word ? wdata[g*BYTE_W +: BYTE_W] : wdata[BYTE_W-1:0];
  end
endmodule

// File: rtl/lsu_load_align.sv
`timescale 1ns/1ps
// Shapes a returned memory word into a register-width load result.
module lsu_load_align
  import lsu_adapt_pkg::*;
#(
  parameter int unsigned LANES = 2,
  localparam int unsigned DATA_W = LANES * BYTE_W,
  localparam int unsigned LSB_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [LSB_W-1:0]  lane,
  input  logic              is_word,
  input  logic              zero_out,
  output logic [DATA_W-1:0] data
);
  logic [BYTE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane == LSB_W'(i)) pick = rdata[i*BYTE_W +: BYTE_W];
    end
  end

  assign data = zero_out ? '0 :
                is_word  ? rdata :
                           {{(DATA_W-BYTE_W){1'b0}}, pick};
endmodule

// File: rtl/lsu_rsp_stage.sv
`timescale 1ns/1ps
// Tracks the one in-flight access and holds its response for the consumer.
module lsu_rsp_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LSB_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [LSB_W-1:0]  in_lane,
  input  logic              in_word,
  input  logic              in_zero,
  input  logic              in_err,
  output logic              req_ready,
  output logic [LSB_W-1:0]  pend_lane,
  output logic              pend_word,
  output logic              pend_zero,
  input  logic [DATA_W-1:0] fmt_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  typedef struct packed {
    logic [LSB_W-1:0] lane;
    logic             word;
    logic             zero;
    logic             err;
  } pend_t;

  logic  pend_q;
  pend_t info_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_err_q;

  // A new access may start only when its response slot will be free on return.
  assign req_ready = !pend_q && (!rsp_valid_q || rsp_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      info_q <= '0;
    end else begin
      pend_q <= fire;
      if (fire) info_q <= '{lane: in_lane, word: in_word, zero: in_zero, err: in_err};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_err_q   <= 1'b0;
    end else if (pend_q) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= fmt_data;
      rsp_err_q   <= info_q.err;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign pend_lane = info_q.lane;
  assign pend_word = info_q.word;
  assign pend_zero = info_q.zero;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_err   = rsp_err_q;
endmodule

// File: rtl/lsu_byte_word_adapter.sv
`timescale 1ns/1ps
module lsu_byte_word_adapter
  import lsu_adapt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DATA_W  = LANES * BYTE_W,
  localparam int unsigned LSB_W   = $clog2(LANES),
  localparam int unsigned MADDR_W = ADDR_W - LSB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_word,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]   mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_misaligned
);
  logic              fire;
  acc_size_e         size;
  logic [LSB_W-1:0]  lane;
  logic              misaligned;
  logic [LSB_W-1:0]  pend_lane;
  logic              pend_word;
  logic              pend_zero;
  logic [DATA_W-1:0] fmt_data;

  assign fire = req_valid && req_ready;
  assign size = acc_size_e'(req_word);

  lsu_lane_steer #(.ADDR_W(ADDR_W), .LANES(LANES)) u_steer (
    .fire       (fire),
    .addr       (req_addr),
    .size       (size),
    .is_write   (req_write),
    .wdata      (req_wdata),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .lane       (lane),
    .misaligned (misaligned)
  );

  lsu_rsp_stage #(.DATA_W(DATA_W), .LSB_W(LSB_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .in_lane   (lane),
    .in_word   (req_word),
    .in_zero   (req_write || misaligned),
    .in_err    (misaligned),
    .req_ready (req_ready),
    .pend_lane (pend_lane),
    .pend_word (pend_word),
    .pend_zero (pend_zero),
    .fmt_data  (fmt_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_misaligned)
  );

  lsu_load_align #(.LANES(LANES)) u_align (
    .rdata    (mem_rdata),
    .lane     (pend_lane),
    .is_word  (pend_word),
    .zero_out (pend_zero),
    .data     (fmt_data)
  );
endmodule

// File: rtl/lsu_adapter_checker.sv
`timescale 1ns/1ps
module lsu_adapter_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DATA_W = LANES * 8,
  localparam int unsigned LSB_W  = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_word,
  input logic              req_write,
  input logic              mem_en,
  input logic              mem_we,
  input logic [LANES-1:0]  mem_be,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_misaligned
);
  logic acc;
  logic odd;
  assign acc = req_valid && req_ready;
  assign odd = (req_addr[LSB_W-1:0] != '0);

  assert_mem_only_on_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> acc);

  assert_word_store_all_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_word && req_write && !odd) |-> (mem_we && (&mem_be)));

  assert_byte_store_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_word && req_write) |->
      (mem_we && $countones(mem_be) == 1 && mem_be[req_addr[LSB_W-1:0]]));

  assert_odd_word_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_word && odd) |-> (!mem_en && !mem_we));

  assert_odd_word_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_word && odd) |=> ##1 (rsp_valid && rsp_misaligned && rsp_data == '0));

  assert_rsp_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!rsp_valid ##1 rsp_valid));

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_misaligned)));

  assert_backpressure_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind lsu_byte_word_adapter lsu_adapter_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_addr       (req_addr),
  .req_word       (req_word),
  .req_write      (req_write),
  .mem_en         (mem_en),
  .mem_we         (mem_we),
  .mem_be         (mem_be),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_data       (rsp_data),
  .rsp_misaligned (rsp_misaligned)
);

// File: tb/lsu_byte_word_adapter_tb.sv
`timescale 1ns/1ps
module lsu_byte_word_adapter_tb;
  localparam int ADDR_W = 12;
  localparam int WORDS  = 1 << (ADDR_W - 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_ready, req_word, req_write;
  logic [11:0] req_addr;
  logic [15:0] req_wdata;
  logic        mem_en, mem_we;
  logic [10:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        rsp_valid, rsp_ready, rsp_misaligned;
  logic [15:0] rsp_data;

  lsu_byte_word_adapter #(.ADDR_W(ADDR_W), .LANES(2)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_misaligned(rsp_misaligned)
  );

  // Memory array seen by the design, plus an independent expectation copy.
  logic [15:0] mem_arr [WORDS];
  logic [15:0] shadow  [WORDS];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (mem_be[0]) mem_arr[mem_addr][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem_arr[mem_addr][15:8] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= mem_arr[mem_addr];
      end
    end
  end

  int checks = 0;
  int errors = 0;
  int bp_mode = 0;
  logic [16:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [11:0] a, input logic w, input logic wr,
                       input logic [15:0] d);
    logic [10:0] widx;
    logic        mis, e_en, e_we;
    logic [1:0]  e_be;
    logic [15:0] e_wd, e_rd;
    string       tag;
    widx = a[11:1];
    mis  = w && a[0];
    e_en = !mis;
    e_we = !mis && wr;
    e_be = !e_we ? 2'b00 : (w ? 2'b11 : (a[0] ? 2'b10 : 2'b01));
    e_wd = w ? d : {d[7:0], d[7:0]};
    tag  = mis ? "R6" : (wr ? (w ? "R2" : "R3") : (w ? "R4" : "R5"));
    if (mis || wr) e_rd = 16'h0;
    else if (w)    e_rd = shadow[widx];
    else           e_rd = {8'h00, a[0] ? shadow[widx][15:8] : shadow[widx][7:0]};
    if (e_we) begin
      if (e_be[0]) shadow[widx][7:0]  = e_wd[7:0];
      if (e_be[1]) shadow[widx][15:8] = e_wd[15:8];
    end

    @(negedge clk);
    req_addr = a; req_word = w; req_write = wr; req_wdata = d; req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    check(mem_en == e_en, mis ? "R6" : "R1", "mem_en", mem_en, e_en);
    if (e_en) check(mem_addr == widx, "R1", "mem_addr", mem_addr, widx);
    check(mem_we == e_we, tag, "mem_we", mem_we, e_we);
    if (e_we) begin
      check(mem_be == e_be, tag, "mem_be", mem_be, e_be);
      check(mem_wdata == e_wd, tag, "mem_wdata", mem_wdata, e_wd);
    end
    exp_q.push_back({mis, e_rd});
    tag_q.push_back(tag);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Consumer ready pattern, changed just after each rising edge.
  initial begin
    rsp_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      case (bp_mode)
        0: rsp_ready = 1'b1;
        1: rsp_ready = 1'($urandom % 2);
        default: rsp_ready = 1'b0;
      endcase
    end
  end

  // Monitor: scoreboard compare on every response handshake.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected response", rsp_data, 0);
        end else begin
          logic [16:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == e[15:0], t, "rsp_data", rsp_data, e[15:0]);
          check(rsp_misaligned == e[16], t, "rsp_misaligned", rsp_misaligned, e[16]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    for (int i = 0; i < WORDS; i++) begin
      mem_arr[i] = 16'(i * 16'h9E37) ^ 16'h5A0F;
      shadow[i]  = 16'(i * 16'h9E37) ^ 16'h5A0F;
    end
    mem_rdata = 16'h0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_word = 1'b0;
    req_write = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R9", "rsp_valid in reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R9", "req_ready in reset", req_ready, 1);
    check(mem_en == 1'b0, "R9", "mem_en in reset", mem_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed lane-order, extension and merge cases.
    issue(12'h040, 1'b1, 1'b0, 16'h0);      // R4 word load
    issue(12'h040, 1'b0, 1'b0, 16'h0);      // R5 low lane
    issue(12'h041, 1'b0, 1'b0, 16'h0);      // R5 high lane
    issue(12'h041, 1'b0, 1'b1, 16'hA55A);   // R3 upper register bits ignored
    issue(12'h040, 1'b1, 1'b0, 16'h0);      // R3 low byte untouched
    issue(12'h044, 1'b1, 1'b1, 16'h1234);   // R2 word store
    issue(12'h044, 1'b0, 1'b0, 16'h0);      // R5 expects 34
    issue(12'h045, 1'b0, 1'b0, 16'h0);      // R5 expects 12
    issue(12'h047, 1'b1, 1'b1, 16'hFFFF);   // R6 refused store
    issue(12'h047, 1'b1, 1'b0, 16'h0);      // R6 refused load
    issue(12'h046, 1'b1, 1'b0, 16'h0);      // R6 word unchanged
    drain();

    // Held response: latency, stability and blocking (R7, R8).
    bp_mode = 2;
    @(posedge clk);
    #2;
    issue(12'h044, 1'b1, 1'b0, 16'h0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7", "rsp_valid one edge after accept", rsp_valid, 0);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R7", "rsp_valid two edges after accept", rsp_valid, 1);
    held = rsp_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R8", "req_ready while held", req_ready, 0);
      check(rsp_data == held, "R7", "rsp_data while held", rsp_data, held);
    end
    bp_mode = 0;
    drain();

    // Mixed traffic over a small window with random consumer stalls.
    bp_mode = 1;
    for (int n = 0; n < 400; n++) begin
      issue(12'($urandom_range(0, 47)), 1'($urandom % 2), 1'($urandom % 2),
            16'($urandom));
    end
    bp_mode = 0;
    drain();
    for (int a = 0; a < 48; a += 2) issue(12'(a), 1'b1, 1'b0, 16'h0);
    drain();
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule